// File: doc/BRIEF.md
# Masked Data Breakpoint Matcher

This block watches the data side of a processor pipeline for accesses that touch programmed memory regions. It holds a small set of watch channels, two by default. Each channel stores a watch address and a control word. Every presented load or store is compared against all channels in parallel. When at least one channel matches, a registered hit flag and the index of the lowest matching channel appear one cycle later.

A watched region is a naturally aligned power-of-two block, formed by clearing low bits of a six-bit mask. The test is an overlap check: the access matches when any of its bytes falls inside the region. The access is one, two or four bytes wide. Mask bits may also be cleared out of sequence, and each cleared bit then acts as a don't-care. Separate enables select whether loads, stores or both are watched. All hits are held back while the current interrupt level is at or above a configured debug level, so the debug handler cannot trap on itself.

Channels are programmed through a simple write port. One strobe selects the channel and whether the address or the control word is written.

Top module: `dbk_matcher`

## Requirements
- R1: After reset `hit` and `hit_ch` are 0 and every channel has both enables cleared, so no access produces a hit until a control word is written.
- R2: In a control word, bit 30 enables matching on loads (`acc_store`=0) and bit 31 enables matching on stores (`acc_store`=1). An access whose direction is not enabled on a channel never matches that channel.
- R3: Control bits [5:0] are the mask. A watch-address bit i in [5:0] is compared only when mask bit i is 1. Values 0x3F, 0x3E, 0x3C, 0x38, 0x30 and 0x20 watch 1, 2, 4, 8, 16 and 32 bytes. Non-contiguous masks such as 0x35 are accepted, and each 0 bit is a don't-care.
- R4: `acc_size` code 0 is a 1-byte access, code 1 a 2-byte access, and codes 2 and 3 a 4-byte access. A 2-byte access ignores address bit 0 and a 4-byte access ignores bits 1:0, so any overlap of the access bytes with the region matches.
- R5: Address bits 31:6 must equal the watch address exactly for a match.
- R6: When several channels match, `hit_ch` reports the lowest-numbered one.
- R7: No hit is raised while `irq_level` >= DEBUG_LEVEL (default 6).
- R8: `hit` and `hit_ch` are registered: they reflect the access presented in the previous cycle, and no hit follows a cycle with `acc_valid` low.
- R9: A write with `wr_en`=1 updates channel `wr_ch`: the control word if `wr_ctl`=1, otherwise the watch address. The new value applies to accesses from the next cycle. An access in the same cycle as the write uses the old value.
- R10: `hit_ch` is 0 whenever `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Channel register write strobe |
| wr_ch | input | CH_W | Channel selected by the write |
| wr_ctl | input | 1 | 1 writes the control word, 0 writes the watch address |
| wr_data | input | 32 | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2 or 3=4 bytes |
| irq_level | input | LVL_W | Current interrupt level |
| hit | output | 1 | Registered breakpoint hit |
| hit_ch | output | CH_W | Registered index of the lowest matching channel |

## Verification
The bench builds the block with its defaults: two channels, a four-bit interrupt level and a debug level of 6. With two channels, the lowest-index rule can be seen in both orders, and the one-bit channel select reaches every channel. With a four-bit level, the bench can drive levels just below, at and above the debug level. Random accesses are drawn close to the programmed watch addresses, so the masked low bits, the size spans and the exact upper bits are all hit from both sides of each boundary.

// File: rtl/dbk_pkg.sv
package dbk_pkg;

    localparam int ADDR_W = 32;
    localparam int MASK_W = 6;
    localparam int LD_BIT = 30;
    localparam int ST_BIT = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              ld_en;
        logic              st_en;
        logic [MASK_W-1:0] mask;
        logic [ADDR_W-1:0] addr;
    } watch_t;

    // low address bits covered by the access itself
    function automatic logic [MASK_W-1:0] span_bits(input logic [1:0] sz);
        logic [MASK_W-1:0] s;
        case (acc_size_e'(sz))
            SZ_BYTE: s = '0;
            SZ_HALF: s = MASK_W'(1);
            default: s = MASK_W'(3);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dbk_channel.sv
module dbk_channel
    import dbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctl,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              match
);

    watch_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (wr_en) begin
            if (wr_ctl) begin
                w_d.ld_en = wr_data[LD_BIT];
                w_d.st_en = wr_data[ST_BIT];
                w_d.mask  = wr_data[MASK_W-1:0];
            end else begin
                w_d.addr = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    logic [MASK_W-1:0] care;
    logic [ADDR_W-1:0] diff;
    logic              hi_eq, lo_eq, dir_ok;

    always_comb begin
        care   = w_q.mask & ~span_bits(acc_size);
        diff   = acc_addr ^ w_q.addr;
        hi_eq  = (diff[ADDR_W-1:MASK_W] == '0);
        lo_eq  = ((diff[MASK_W-1:0] & care) == '0);
        dir_ok = acc_store ? w_q.st_en : w_q.ld_en;
        match  = acc_valid & dir_ok & hi_eq & lo_eq;
    end

    // R9: clearing both enables stops matching from the next cycle on
    a_r9_disable_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctl && wr_data[ST_BIT:LD_BIT] == 2'b00) |=> !match);

    // R2: a store-only control word never matches a load in the next cycle
    a_r2_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctl && wr_data[ST_BIT:LD_BIT] == 2'b10) |=> !(match && !acc_store));

endmodule

// File: rtl/dbk_prio.sv
module dbk_prio #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any,
    output logic [CH_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/dbk_matcher.sv
module dbk_matcher
    import dbk_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int LVL_W       = 4,
    parameter int DEBUG_LEVEL = 6,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_ctl,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [LVL_W-1:0]  irq_level,
    output logic              hit,
    output logic [CH_W-1:0]   hit_ch
);

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } out_t;

    logic [NUM_CH-1:0] match_vec;
    logic              any_match;
    logic [CH_W-1:0]   low_idx;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dbk_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_ch == CH_W'(c))),
            .wr_ctl   (wr_ctl),
            .wr_data  (wr_data),
            .acc_valid(acc_valid),
            .acc_store(acc_store),
            .acc_addr (acc_addr),
            .acc_size (acc_size),
            .match    (match_vec[c])
        );
    end

    dbk_prio #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_prio (
        .req(match_vec),
        .any(any_match),
        .idx(low_idx)
    );

    out_t o_d, o_q;
    logic lvl_ok;

    always_comb begin
        lvl_ok   = (irq_level < LVL_W'(DEBUG_LEVEL));
        o_d.hit  = acc_valid && lvl_ok && any_match;
        o_d.ch   = o_d.hit ? low_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hit    = o_q.hit;
    assign hit_ch = o_q.ch;

    // R8: a hit always follows a valid access
    a_r8_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(acc_valid));

    // R7: nothing reported for accesses made at or above the debug level
    a_r7_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(irq_level) < LVL_W'(DEBUG_LEVEL));

    // R10: index parked at zero when idle
    a_r10_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> hit_ch == '0);

    // R6: a nonzero index means channel 0 did not match
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_ch != '0) |-> !$past(match_vec[0]));

endmodule

// File: tb/dbk_matcher_test.sv
module dbk_matcher_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_ctl, acc_valid, acc_store;
    logic [0:0]  wr_ch;
    logic [31:0] wr_data, acc_addr;
    logic [1:0]  acc_size;
    logic [3:0]  irq_level;
    logic        hit;
    logic [0:0]  hit_ch;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_addr [2];
    logic [5:0]  m_mask [2];
    logic        m_ld   [2];
    logic        m_st   [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbk_matcher uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_ctl(wr_ctl),
        .wr_data(wr_data), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .acc_size(acc_size), .irq_level(irq_level),
        .hit(hit), .hit_ch(hit_ch)
    );

    function automatic logic ch_hit(int c, logic st, logic [31:0] a, logic [1:0] sz);
        logic [5:0]  ign;
        logic [5:0]  care;
        logic [31:0] d;
        ign  = (sz == 2'd0) ? 6'd0 : (sz == 2'd1) ? 6'd1 : 6'd3;
        care = m_mask[c] & ~ign;
        d    = a ^ m_addr[c];
        if (!(st ? m_st[c] : m_ld[c])) return 1'b0;
        if (d[31:6] != 26'd0) return 1'b0;
        return (d[5:0] & care) == 6'd0;
    endfunction

    // presents one cycle of stimulus at a falling edge and checks the next falling edge
    task automatic step(input logic v, input logic st, input logic [31:0] a, input logic [1:0] sz,
                        input logic [3:0] lvl, input logic we, input logic wc, input logic wctl,
                        input logic [31:0] wd, input string req);
        logic       e_hit;
        logic [0:0] e_ch;
        logic       h0, h1;
        h0 = ch_hit(0, st, a, sz);
        h1 = ch_hit(1, st, a, sz);
        e_hit = v && (lvl < 4'd6) && (h0 || h1);
        e_ch  = (e_hit && !h0) ? 1'b1 : 1'b0;
        acc_valid = v; acc_store = st; acc_addr = a; acc_size = sz; irq_level = lvl;
        wr_en = we; wr_ch = wc; wr_ctl = wctl; wr_data = wd;
        if (we) begin
            if (wctl) begin
                m_ld[wc] = wd[30]; m_st[wc] = wd[31]; m_mask[wc] = wd[5:0];
            end else begin
                m_addr[wc] = wd;
            end
        end
        @(negedge clk);
        n_vec++;
        if (hit !== e_hit || hit_ch !== e_ch) begin
            n_bad++;
            $display("FAIL %s: addr=%h sz=%0d st=%0b lvl=%0d got hit=%b ch=%0d expected hit=%b ch=%0d",
                     req, a, sz, st, lvl, hit, hit_ch, e_hit, e_ch);
        end
        acc_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic c, input logic ctl, input logic [31:0] d, input string req);
        step(1'b0, 1'b0, 32'd0, 2'd0, 4'd0, 1'b1, c, ctl, d, req);
    endtask

    task automatic acc(input logic st, input logic [31:0] a, input logic [1:0] sz,
                       input logic [3:0] lvl, input string req);
        step(1'b1, st, a, sz, lvl, 1'b0, 1'b0, 1'b0, 32'd0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_addr[c] = '0; m_mask[c] = '0; m_ld[c] = 1'b0; m_st[c] = 1'b0;
        end
        rst_n = 1'b0; wr_en = 0; wr_ch = 0; wr_ctl = 0; wr_data = 0;
        acc_valid = 0; acc_store = 0; acc_addr = 0; acc_size = 0; irq_level = 0;
        repeat (3) @(negedge clk);
        n_vec++;
        if (hit !== 1'b0 || hit_ch !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got hit=%b ch=%0d expected hit=0 ch=0", hit, hit_ch);
        end
        rst_n = 1'b1;
        // R1: cleared channels never hit
        acc(1'b0, 32'h0000_0000, 2'd0, 4'd0, "R1");
        acc(1'b1, 32'h0000_0000, 2'd2, 4'd0, "R1");

        // R3 one-byte exact, load enabled on channel 0
        wr(1'b0, 1'b1, 32'h4000_003F, "R9");
        wr(1'b0, 1'b0, 32'hD000_007F, "R9");
        acc(1'b0, 32'hD000_007F, 2'd0, 4'd0, "R3");
        acc(1'b0, 32'hD000_007E, 2'd0, 4'd0, "R3");
        // R2: store not enabled
        acc(1'b1, 32'hD000_007F, 2'd0, 4'd0, "R2");
        // R4 overlap: 2-byte at 7E covers 7F, 4-byte at 7C covers 7F
        acc(1'b0, 32'hD000_007E, 2'd1, 4'd0, "R4");
        acc(1'b0, 32'hD000_007C, 2'd2, 4'd0, "R4");
        acc(1'b0, 32'hD000_007C, 2'd3, 4'd0, "R4");
        acc(1'b0, 32'hD000_0078, 2'd2, 4'd0, "R4");
        // R5 upper bits differ
        acc(1'b0, 32'h5000_007F, 2'd0, 4'd0, "R5");
        acc(1'b0, 32'hD000_00BF, 2'd0, 4'd0, "R5");
        // R7 level gate
        acc(1'b0, 32'hD000_007F, 2'd0, 4'd5, "R7");
        acc(1'b0, 32'hD000_007F, 2'd0, 4'd6, "R7");
        acc(1'b0, 32'hD000_007F, 2'd0, 4'd15, "R7");
        // R3 32-byte region, store-only on channel 1
        wr(1'b1, 1'b1, 32'h8000_0020, "R9");
        wr(1'b1, 1'b0, 32'hD000_0060, "R9");
        acc(1'b1, 32'hD000_0074, 2'd2, 4'd0, "R3");
        acc(1'b1, 32'hD000_005C, 2'd2, 4'd0, "R3");
        acc(1'b0, 32'hD000_0074, 2'd2, 4'd0, "R2");
        // R3 don't-care bits in the watch address, non-contiguous mask
        wr(1'b0, 1'b1, 32'h4000_0030, "R9");
        wr(1'b0, 1'b0, 32'hD000_0071, "R9");
        acc(1'b0, 32'hD000_0070, 2'd1, 4'd0, "R3");
        wr(1'b0, 1'b1, 32'h4000_0035, "R9");
        wr(1'b0, 1'b0, 32'hD000_0072, "R9");
        acc(1'b0, 32'hD000_0070, 2'd2, 4'd0, "R3");
        acc(1'b0, 32'hD000_0074, 2'd2, 4'd0, "R3");
        // R6 both channels match: channel 0 wins; only channel 1: index 1
        wr(1'b0, 1'b1, 32'hC000_0020, "R9");
        wr(1'b0, 1'b0, 32'hD000_0060, "R9");
        acc(1'b1, 32'hD000_0064, 2'd2, 4'd0, "R6");
        wr(1'b0, 1'b1, 32'h4000_0020, "R9");
        acc(1'b1, 32'hD000_0064, 2'd2, 4'd0, "R6");
        // R8 valid low: no hit
        step(1'b0, 1'b1, 32'hD000_0064, 2'd2, 4'd0, 1'b0, 1'b0, 1'b0, 32'd0, "R8");
        // R9 same-cycle write uses old value, next cycle the new one
        step(1'b1, 1'b1, 32'hD000_0064, 2'd2, 4'd0, 1'b1, 1'b1, 1'b1, 32'h0000_0020, "R9");
        acc(1'b1, 32'hD000_0064, 2'd2, 4'd0, "R9");
        // R10 covered by every no-hit vector; random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  c;
            logic [31:0] a;
            if (i % 150 == 0) begin
                for (int k = 0; k < 2; k++) begin
                    logic [5:0] mk;
                    case ($urandom % 8)
                        0: mk = 6'h3F; 1: mk = 6'h3E; 2: mk = 6'h3C; 3: mk = 6'h38;
                        4: mk = 6'h30; 5: mk = 6'h20; default: mk = 6'($urandom);
                    endcase
                    wr(k[0], 1'b1, {2'($urandom), 24'd0, mk}, "R9");
                    wr(k[0], 1'b0, 32'hD000_0040 ^ ($urandom & 32'hFF), "R9");
                end
            end
            c = 2'($urandom % 2);
            a = m_addr[c] ^ ($urandom & 32'h7F);
            if ($urandom % 8 == 0) a = a ^ (32'd1 << (6 + $urandom % 26));
            acc(1'($urandom), a, 2'($urandom), 4'($urandom % 9), "R3 R4 R5 R6 R7 R10 random");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule